// File: doc/BRIEF.md
# CPU Status Flag Control Unit

This block holds the processor status word of a small 16-bit CPU and drives the two pieces of logic that depend on its bits. The word has five live bits. Two are mode bits. A wait-polarity bit decides whether the bit-polling wait instruction holds the pipeline until the polled bit reads 1 or until it reads 0. A pointer-mode bit decides whether a load with pointer update steps the data RAM pointer up or down by one. The other three bits are result flags: carry, zero and condition. The ALU and the compare unit write these flags.

Software can change any single bit with a dedicated set or clear command, and it can write or read the whole word. Hardware flag updates come in through separate strobes. When a software action and a hardware update hit the same bit in the same cycle, the software action takes effect. The wait stall output and the next pointer value are both combinational. Instruction decode, the ALU and the RAM sit outside this block and reach it only through these ports.

Top module: `cpu_flag_ctrl`

## Requirements
- R1: After reset the word reads 0x0018. That is wait-polarity (bit 4) = 1, pointer-mode (bit 3) = 1, and condition (bit 2), zero (bit 1) and carry (bit 0) all 0.
- R2: Bits 15 to 5 of `rd_data` always read 0, whatever value is written to them.
- R3: A cycle with `sw_wr_en` high loads `sw_wr_data[4:0]` into the five live bits, and the new value is visible on the next cycle.
- R4: `bit_set[i]` forces bit i to 1 on the next cycle and `bit_clr[i]` forces it to 0. If both are high for the same bit, the clear wins.
- R5: For a given bit, a set or clear command beats a whole-word write, and either software action beats a hardware update in the same cycle.
- R6: With `alu_upd` high, zero (bit 1) takes `alu_zero` and carry (bit 0) takes `alu_carry` on the next cycle. This covers add, subtract, their with-carry forms and shifts.
- R7: With `cmp_upd` high, condition (bit 2) takes `cmp_true` on the next cycle.
- R8: `stall` is high, in the same cycle, exactly when `wait_active` is high and `poll_bit` differs from bit 4.
- R9: With `ld_upd` high, `ptr_out` is `ptr_in`+1 when bit 3 is 1 and `ptr_in`-1 when bit 3 is 0, wrapping modulo 2^PTR_W. With `ld_upd` low it equals `ptr_in`.
- R10: In a cycle with no write, no command and no update, all bits keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| sw_wr_en | input | 1 | Write strobe for the whole word |
| sw_wr_data | input | 16 | Value for a whole-word write |
| rd_data | output | 16 | Current status word |
| bit_set | input | 5 | Per-bit set commands, index = bit position |
| bit_clr | input | 5 | Per-bit clear commands, index = bit position |
| alu_upd | input | 1 | ALU flag update strobe |
| alu_zero | input | 1 | ALU result was zero |
| alu_carry | input | 1 | ALU carry or borrow out |
| cmp_upd | input | 1 | Compare result strobe |
| cmp_true | input | 1 | Compare outcome |
| wait_active | input | 1 | Wait-on-bit-state instruction is executing |
| poll_bit | input | 1 | Bit being polled by the wait instruction |
| stall | output | 1 | Hold the pipeline |
| ptr_in | input | PTR_W (8) | Current load pointer |
| ld_upd | input | 1 | Load with pointer update this cycle |
| ptr_out | output | PTR_W (8) | Pointer after the post-update |

## Verification
The hardest cases to reach are the priority collisions: one bit receives a clear, a set, a whole-word write and a hardware update all in the same cycle, and each shadowed source must be shown to have no effect. Directed steps build each collision and choose the losing source so that its value is the opposite of the expected result. A long random phase then drives sparse, overlapping commands that a per-cycle reference model tracks. The pointer wrap at both ends is driven directly with all-ones and all-zero pointers in each mode.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int REG_W  = 16;
  localparam int IMPL_W = 5;

  // bit positions inside the status word
  localparam int B_CARRY = 0;
  localparam int B_ZERO  = 1;
  localparam int B_COND  = 2;
  localparam int B_PMODE = 3;
  localparam int B_WPOL  = 4;

  localparam logic [IMPL_W-1:0] RST_VAL = 5'b11000;

  typedef struct packed {
    logic wpol;
    logic pmode;
    logic cond;
    logic zero;
    logic carry;
  } flags_t;
endpackage

// File: rtl/flag_rst_sync.sv
module flag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/flag_bits.sv
module flag_bits
  import flag_pkg::*;
#(
  parameter int                W     = IMPL_W,
  parameter logic [W-1:0]      RVAL  = RST_VAL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cmd_set,
  input  logic [W-1:0] cmd_clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] hw_upd,
  input  logic [W-1:0] hw_val,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic d;
    logic en;

    // priority: clear, set, word write, hardware update
    always_comb begin
      en = cmd_clr[i] | cmd_set[i] | wr_en | hw_upd[i];
      if (cmd_clr[i])      d = 1'b0;
      else if (cmd_set[i]) d = 1'b1;
      else if (wr_en)      d = wr_val[i];
      else                 d = hw_val[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= RVAL[i];
      else if (en) q[i] <= d;
    end
  end
endmodule

// File: rtl/flag_wait_gate.sv
module flag_wait_gate (
  input  logic active,
  input  logic polled,
  input  logic polarity,
  output logic hold
);
  assign hold = active & (polled ^ polarity);
endmodule

// File: rtl/flag_ptr_step.sv
module flag_ptr_step #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] p_in,
  input  logic          upd,
  input  logic          up,
  output logic [PW-1:0] p_out
);
  localparam logic [PW-1:0] ONE = PW'(1);

  always_comb begin
    if (!upd)    p_out = p_in;
    else if (up) p_out = p_in + ONE;
    else         p_out = p_in - ONE;
  end
endmodule

// File: rtl/cpu_flag_ctrl.sv
module cpu_flag_ctrl
  import flag_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_en,
  input  logic [REG_W-1:0]  sw_wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [IMPL_W-1:0] bit_set,
  input  logic [IMPL_W-1:0] bit_clr,
  input  logic              alu_upd,
  input  logic              alu_zero,
  input  logic              alu_carry,
  input  logic              cmp_upd,
  input  logic              cmp_true,
  input  logic              wait_active,
  input  logic              poll_bit,
  output logic              stall,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic              ld_upd,
  output logic [PTR_W-1:0]  ptr_out
);
  localparam int RSV_W = REG_W - IMPL_W;

  logic        rst_sync_n;
  flags_t      flags;
  flags_t      hw_upd;
  flags_t      hw_val;
  logic        unused_wr_hi;

  assign unused_wr_hi = ^sw_wr_data[REG_W-1:IMPL_W];

  flag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    hw_upd       = '0;
    hw_val       = '0;
    hw_upd.carry = alu_upd;
    hw_val.carry = alu_carry;
    hw_upd.zero  = alu_upd;
    hw_val.zero  = alu_zero;
    hw_upd.cond  = cmp_upd;
    hw_val.cond  = cmp_true;
  end

  flag_bits #(.W(IMPL_W), .RVAL(RST_VAL)) u_bits (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd_set (bit_set),
    .cmd_clr (bit_clr),
    .wr_en   (sw_wr_en),
    .wr_val  (sw_wr_data[IMPL_W-1:0]),
    .hw_upd  (hw_upd),
    .hw_val  (hw_val),
    .q       (flags)
  );

  assign rd_data = {{RSV_W{1'b0}}, flags};

  flag_wait_gate u_wait (
    .active   (wait_active),
    .polled   (poll_bit),
    .polarity (flags.wpol),
    .hold     (stall)
  );

  flag_ptr_step #(.PW(PTR_W)) u_ptr (
    .p_in  (ptr_in),
    .upd   (ld_upd),
    .up    (flags.pmode),
    .p_out (ptr_out)
  );
endmodule

// File: rtl/cpu_flag_ctrl_chk.sv
module cpu_flag_ctrl_chk
  import flag_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              sw_wr_en,
  input logic [REG_W-1:0]  rd_data,
  input logic [IMPL_W-1:0] bit_set,
  input logic [IMPL_W-1:0] bit_clr,
  input logic              alu_upd,
  input logic              alu_zero,
  input logic              alu_carry,
  input logic              cmp_upd,
  input logic              cmp_true,
  input logic              wait_active,
  input logic              poll_bit,
  input logic              stall,
  input logic [PTR_W-1:0]  ptr_in,
  input logic              ld_upd,
  input logic [PTR_W-1:0]  ptr_out
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data[REG_W-1:IMPL_W] == '0);

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_clr[B_CARRY] |=> !rd_data[B_CARRY]);

  a_r5_set_beats_hw: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bit_set[B_ZERO] && !bit_clr[B_ZERO]) |=> rd_data[B_ZERO]);

  a_r6_zero_follows_alu: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_upd && !sw_wr_en && bit_set[B_ZERO] == 1'b0 && bit_clr[B_ZERO] == 1'b0)
      |=> rd_data[B_ZERO] == $past(alu_zero));

  a_r7_cond_follows_cmp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmp_upd && !sw_wr_en && bit_set[B_COND] == 1'b0 && bit_clr[B_COND] == 1'b0)
      |=> rd_data[B_COND] == $past(cmp_true));

  a_r8_stall_released: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wait_active && poll_bit == rd_data[B_WPOL]) |-> !stall);

  a_r8_stall_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wait_active && poll_bit != rd_data[B_WPOL]) |-> stall);

  a_r9_ptr_inc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld_upd && rd_data[B_PMODE]) |-> ptr_out == ptr_in + ONE);

  a_r9_ptr_dec: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld_upd && !rd_data[B_PMODE]) |-> ptr_out == ptr_in - ONE);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sw_wr_en && bit_set == '0 && bit_clr == '0 && !alu_upd && !cmp_upd)
      |=> $stable(rd_data));
endmodule

bind cpu_flag_ctrl cpu_flag_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .sw_wr_en    (sw_wr_en),
  .rd_data     (rd_data),
  .bit_set     (bit_set),
  .bit_clr     (bit_clr),
  .alu_upd     (alu_upd),
  .alu_zero    (alu_zero),
  .alu_carry   (alu_carry),
  .cmp_upd     (cmp_upd),
  .cmp_true    (cmp_true),
  .wait_active (wait_active),
  .poll_bit    (poll_bit),
  .stall       (stall),
  .ptr_in      (ptr_in),
  .ld_upd      (ld_upd),
  .ptr_out     (ptr_out)
);

// File: tb/cpu_flag_ctrl_bench.sv
module cpu_flag_ctrl_bench;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sw_wr_en;
  logic [15:0]   sw_wr_data;
  logic [15:0]   rd_data;
  logic [4:0]    bit_set, bit_clr;
  logic          alu_upd, alu_zero, alu_carry;
  logic          cmp_upd, cmp_true;
  logic          wait_active, poll_bit, stall;
  logic [PW-1:0] ptr_in, ptr_out;
  logic          ld_upd;

  int n_chk  = 0;
  int n_fail = 0;
  int ref_w;
  int rcnt;
  bit finished = 0;

  always #4 clk = ~clk;

  cpu_flag_ctrl #(.PTR_W(PW)) u_cpu_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .rd_data(rd_data), .bit_set(bit_set), .bit_clr(bit_clr),
    .alu_upd(alu_upd), .alu_zero(alu_zero), .alu_carry(alu_carry),
    .cmp_upd(cmp_upd), .cmp_true(cmp_true), .wait_active(wait_active),
    .poll_bit(poll_bit), .stall(stall), .ptr_in(ptr_in), .ld_upd(ld_upd),
    .ptr_out(ptr_out)
  );

  // behavioural reference: reset is seen for two edges after release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_w = 'h18;
      rcnt  = 0;
    end else if (rcnt < 2) begin
      rcnt  = rcnt + 1;
      ref_w = 'h18;
    end else begin
      int nw;
      nw = ref_w;
      if (alu_upd) begin
        nw[0] = alu_carry;
        nw[1] = alu_zero;
      end
      if (cmp_upd) nw[2] = cmp_true;
      for (int i = 0; i < 5; i++) begin
        if (sw_wr_en)        nw[i] = sw_wr_data[i];
        if (bit_set[i])      nw[i] = 1;
        if (bit_clr[i])      nw[i] = 0;
      end
      ref_w = nw & 'h1f;
    end
  end

  task automatic fail_msg(string tag, string what, int act, int exp);
    n_fail++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic chk(string tag);
    int exp_stall;
    int exp_ptr;
    exp_stall = (wait_active && (poll_bit != ref_w[4])) ? 1 : 0;
    if (!ld_upd)       exp_ptr = ptr_in;
    else if (ref_w[3]) exp_ptr = (int'(ptr_in) + 1) % 256;
    else               exp_ptr = (int'(ptr_in) + 255) % 256;
    n_chk++;
    if (int'(rd_data) != ref_w) fail_msg(tag, "rd_data", rd_data, ref_w);
    n_chk++;
    if (int'(stall) != exp_stall) fail_msg("R8", "stall", stall, exp_stall);
    n_chk++;
    if (int'(ptr_out) != exp_ptr) fail_msg("R9", "ptr_out", ptr_out, exp_ptr);
  endtask

  task automatic idle();
    sw_wr_en = 0; sw_wr_data = '0; bit_set = '0; bit_clr = '0;
    alu_upd = 0; alu_zero = 0; alu_carry = 0; cmp_upd = 0; cmp_true = 0;
    wait_active = 0; poll_bit = 0; ld_upd = 0; ptr_in = '0;
  endtask

  // check now, then move to the next falling edge
  task automatic tick(string tag);
    #1;
    chk(tag);
    @(negedge clk);
  endtask

  task automatic expect_word(string tag, int exp);
    #1;
    n_chk++;
    if (int'(rd_data) != exp) fail_msg(tag, "word", rd_data, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    expect_word("R1", 'h18);          // R1 during reset
    rst_n = 1;
    repeat (3) tick("R1");
    expect_word("R1", 'h18);          // R1 after release

    // R3 / R2: write all ones, reserved bits must stay zero
    sw_wr_en = 1; sw_wr_data = 16'hFFFF; tick("R3"); idle();
    expect_word("R2", 'h1F); tick("R2");
    sw_wr_en = 1; sw_wr_data = 16'hFFE0; tick("R3"); idle();
    expect_word("R3", 'h00); tick("R3");
    sw_wr_en = 1; sw_wr_data = 16'h0015; tick("R3"); idle();
    expect_word("R3", 'h15); tick("R10");
    tick("R10");

    // R4: per-bit set and clear, clear wins on collision
    for (int i = 0; i < 5; i++) begin
      bit_set = 5'(1 << i); tick("R4"); idle();
      bit_clr = 5'(1 << i); tick("R4"); idle();
    end
    bit_set = 5'h1F; tick("R4"); idle();
    bit_set = 5'h1F; bit_clr = 5'h1F; tick("R4"); idle();
    expect_word("R4", 'h00); tick("R4");

    // R5: command beats word write and hardware update
    bit_set = 5'h07; sw_wr_en = 1; sw_wr_data = 16'h0000;
    alu_upd = 1; alu_zero = 0; alu_carry = 0; cmp_upd = 1; cmp_true = 0;
    tick("R5"); idle();
    expect_word("R5", 'h07); tick("R5");
    bit_clr = 5'h07; alu_upd = 1; alu_zero = 1; alu_carry = 1;
    cmp_upd = 1; cmp_true = 1; tick("R5"); idle();
    expect_word("R5", 'h00); tick("R5");
    sw_wr_en = 1; sw_wr_data = 16'h0018; alu_upd = 1; alu_zero = 1;
    alu_carry = 1; cmp_upd = 1; cmp_true = 1; tick("R5"); idle();
    expect_word("R5", 'h18); tick("R5");

    // R6 / R7: hardware updates
    alu_upd = 1; alu_zero = 1; alu_carry = 0; tick("R6"); idle();
    expect_word("R6", 'h1A); tick("R6");
    alu_upd = 1; alu_zero = 0; alu_carry = 1; tick("R6"); idle();
    expect_word("R6", 'h19); tick("R6");
    alu_zero = 1; alu_carry = 0; tick("R10"); idle();
    expect_word("R10", 'h19); tick("R10");
    cmp_upd = 1; cmp_true = 1; tick("R7"); idle();
    expect_word("R7", 'h1D); tick("R7");
    cmp_upd = 1; cmp_true = 0; tick("R7"); idle();
    expect_word("R7", 'h19); tick("R7");

    // R8: stall for both polarities
    for (int pol = 0; pol < 2; pol++) begin
      if (pol == 0) bit_clr = 5'h10; else bit_set = 5'h10;
      tick("R8"); idle();
      for (int a = 0; a < 2; a++)
        for (int p = 0; p < 2; p++) begin
          wait_active = a[0]; poll_bit = p[0]; tick("R8");
        end
      idle();
    end

    // R9: pointer step and wrap in both modes
    bit_set = 5'h08; tick("R9"); idle();
    ld_upd = 1; ptr_in = 8'hFF; tick("R9");
    ptr_in = 8'h41; tick("R9");
    ld_upd = 0; tick("R9");
    bit_clr = 5'h08; tick("R9"); idle();
    ld_upd = 1; ptr_in = 8'h00; tick("R9");
    ptr_in = 8'h80; tick("R9");
    idle();

    // random overlap phase
    for (int n = 0; n < 3000; n++) begin
      sw_wr_en    = ($urandom % 8) == 0;
      sw_wr_data  = 16'($urandom);
      bit_set     = (($urandom % 4) == 0) ? 5'($urandom) : 5'h0;
      bit_clr     = (($urandom % 4) == 0) ? 5'($urandom) : 5'h0;
      alu_upd     = ($urandom % 3) == 0;
      alu_zero    = 1'($urandom);
      alu_carry   = 1'($urandom);
      cmp_upd     = ($urandom % 3) == 0;
      cmp_true    = 1'($urandom);
      wait_active = 1'($urandom);
      poll_bit    = 1'($urandom);
      ld_upd      = 1'($urandom);
      ptr_in      = PW'($urandom);
      tick("R5");
    end
    idle();
    tick("R10");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule